// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block sits between a set of device interrupt request lines and the processors of a chip. For every device source it keeps a routing entry that names the target processor and the vector to deliver. Next to that routing entry it keeps a control entry with a mask bit and a pending bit. Software programs and inspects both kinds of entry through a register port with 64-bit data. The block announces each interrupt it accepts on a single post output, a one-cycle valid strobe that carries a processor number and a vector.

A request arriving from an unmasked source is accepted. Accepting it sets that source's pending bit and also masks the source again, so the source stays silent until software unmasks it. A request from a masked source is discarded. Accepted requests wait in a latch set. A small state machine drains that set one request per cycle, lowest source index first. It has two states. `PST_IDLE` means nothing is being posted, and `PST_ISSUE` means `post_valid` is high this cycle. The transitions are: IDLE->ISSUE when the latch set is non-empty at a clock edge, ISSUE->ISSUE while it stays non-empty, ISSUE->IDLE when it is empty, and IDLE->IDLE otherwise. The routing entry is read at the clock edge that issues the post.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every control entry reads 0x4 (masked, not pending), every routing entry reads 0, and `post_valid` is low.
- R2: A routing entry stores the target processor from write-data bits 12:8 and the vector from bits 5:0. A read returns those fields at the same positions, and every other bit reads as 0.
- R3: A control entry read returns the mask in bit 2 and the pending flag in bit 0, and every other bit reads as 0.
- R4: A control write loads the mask from bit 2. A 1 in bit 1 clears pending, and a 0 in bit 1 leaves pending as it was.
- R5: A request from a masked source is dropped. No post follows and the control entry does not change.
- R6: A request from an unmasked source, sampled at clock edge k, sets mask and pending at edge k. At edge k+1 `post_valid` rises for one cycle, carrying the entry's processor and vector.
- R7: An accepted source stays masked. Further requests, including a line held high for many cycles, give no further post until software clears the mask.
- R8: When several sources are accepted together, they post on consecutive cycles in ascending index order.
- R9: An access to an unmapped offset sets `reg_err` for exactly the one cycle after the access. A read of such an offset returns 0, and a write to it changes no entry.
- R10: The entry index is the byte offset shifted right by 3, so the low three offset bits are ignored. Routing entries start at offset 0 and control entries start at `CTL_BASE` (default 0x200). An access to a mapped offset leaves `reg_err` low.
- R11: When a request and a control write hit the same source in the same cycle, the mask as it was before that edge decides. An accepted request leaves the entry masked and pending, whatever the write carried. A dropped request lets the write take full effect.
- R12: Read data appears in `reg_rdata` one cycle after the access and reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | N_SRC | Request lines from the device sources, sampled each edge |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Unmapped-offset flag, one cycle after the access |
| post_valid | output | 1 | One-cycle strobe per posted interrupt |
| post_cpu | output | 5 | Target processor of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
Two functions can land on the same entry in the same cycle: a hardware acceptance of a request and a software control write to that entry. The bench provokes this by driving the request line and the control write on the same falling edge, once for a source that is unmasked and once for a source that is masked. It then judges the result by whether a post appears two edges later and by reading the control entry back: 0x5 in the first case and 0x0 in the second. A second collision is three sources accepted together, judged by the order and the cycle of each post.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;
    localparam int DATA_W   = 64;
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int MASK_BIT = 2;
    localparam int CLR_BIT  = 1;
    localparam int PEND_BIT = 0;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;

    typedef enum logic [0:0] {
        PST_IDLE  = 1'b0,
        PST_ISSUE = 1'b1
    } post_state_e;
endpackage

// File: rtl/irq_route_decode.sv
`timescale 1ns/1ps
module irq_route_decode #(
    parameter int          N_SRC    = 32,
    parameter int          ADDR_W   = 16,
    parameter int unsigned CTL_BASE = 'h200,
    localparam int         IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_route,
    output logic              hit_ctl,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(N_SRC * 8);
    localparam logic [ADDR_W:0] CTL_LO = (ADDR_W+1)'(CTL_BASE);
    localparam logic [ADDR_W:0] CTL_HI = CTL_LO + SPAN;

    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] ctl_off;

    assign addr_x    = {1'b0, addr};
    assign ctl_off   = addr - CTL_LO[ADDR_W-1:0];
    assign hit_route = addr_x < SPAN;
    assign hit_ctl   = (addr_x >= CTL_LO) && (addr_x < CTL_HI);
    assign idx       = hit_ctl ? ctl_off[IDX_W+2:3] : addr[IDX_W+2:3];
endmodule

// File: rtl/irq_route_bank.sv
`timescale 1ns/1ps
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int  N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] dev_irq,
    input  logic             wr_route,
    input  logic             wr_ctl,
    input  logic [IDX_W-1:0] idx,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             wr_mask,
    input  logic             wr_clr,
    output route_t           route_tbl [N_SRC],
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] accept
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_ent
        logic   m_r;
        logic   p_r;
        route_t r_r;
        logic   sel;
        logic   acc;

        assign sel = (idx == IDX_W'(g));
        assign acc = dev_irq[g] & ~m_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                m_r <= 1'b1;
                p_r <= 1'b0;
                r_r <= '0;
            end else begin
                if (wr_route && sel) begin
                    r_r.cpu <= wr_cpu;
                    r_r.vec <= wr_vec;
                end
                if (acc) begin
                    m_r <= 1'b1;
                    p_r <= 1'b1;
                end else if (wr_ctl && sel) begin
                    m_r <= wr_mask;
                    if (wr_clr) p_r <= 1'b0;
                end
            end
        end

        assign route_tbl[g] = r_r;
        assign mask_q[g]    = m_r;
        assign pend_q[g]    = p_r;
        assign accept[g]    = acc;
    end
endmodule

// File: rtl/irq_route_post.sv
`timescale 1ns/1ps
module irq_route_post
    import irq_route_pkg::*;
#(
    parameter int  N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] accept,
    input  route_t           route_tbl [N_SRC],
    output logic             post_valid,
    output logic [CPU_W-1:0] post_cpu,
    output logic [VEC_W-1:0] post_vec
);
    post_state_e      state_q;
    post_state_e      state_d;
    logic [N_SRC-1:0] wait_q;
    logic [N_SRC-1:0] pick_oh;
    logic [IDX_W-1:0] pick_idx;
    logic             any_wait;
    route_t           held_q;

    assign any_wait = |wait_q;
    assign pick_oh  = wait_q & (~wait_q + N_SRC'(1));

    always_comb begin
        pick_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (wait_q[i]) pick_idx = IDX_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PST_IDLE:  state_d = any_wait ? PST_ISSUE : PST_IDLE;
            PST_ISSUE: state_d = any_wait ? PST_ISSUE : PST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
            held_q <= '0;
        end else begin
            wait_q <= (wait_q & ~pick_oh) | accept;
            if (any_wait) held_q <= route_tbl[pick_idx];
        end
    end

    always_comb begin
        post_valid = (state_q == PST_ISSUE);
        post_cpu   = post_valid ? held_q.cpu : '0;
        post_vec   = post_valid ? held_q.vec : '0;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int          N_SRC    = 32,
    parameter int          ADDR_W   = 16,
    parameter int unsigned CTL_BASE = 'h200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  dev_irq,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    output logic              post_valid,
    output logic [4:0]        post_cpu,
    output logic [5:0]        post_vec
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             hit_route;
    logic             hit_ctl;
    logic [IDX_W-1:0] idx;
    logic             wr_route;
    logic             wr_ctl;
    route_t           route_tbl [N_SRC];
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] accept;
    logic [63:0]      rd_word;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[63:13], reg_wdata[7:6]};

    irq_route_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .CTL_BASE(CTL_BASE)) u_dec (
        .addr      (reg_addr),
        .hit_route (hit_route),
        .hit_ctl   (hit_ctl),
        .idx       (idx)
    );

    assign wr_route = reg_en & reg_we & hit_route;
    assign wr_ctl   = reg_en & reg_we & hit_ctl;

    irq_route_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .dev_irq   (dev_irq),
        .wr_route  (wr_route),
        .wr_ctl    (wr_ctl),
        .idx       (idx),
        .wr_cpu    (reg_wdata[CPU_LSB +: CPU_W]),
        .wr_vec    (reg_wdata[VEC_LSB +: VEC_W]),
        .wr_mask   (reg_wdata[MASK_BIT]),
        .wr_clr    (reg_wdata[CLR_BIT]),
        .route_tbl (route_tbl),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .accept    (accept)
    );

    irq_route_post #(.N_SRC(N_SRC)) u_post (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .route_tbl  (route_tbl),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    always_comb begin
        rd_word = '0;
        if (hit_route) begin
            rd_word[CPU_LSB +: CPU_W] = route_tbl[idx].cpu;
            rd_word[VEC_LSB +: VEC_W] = route_tbl[idx].vec;
        end else if (hit_ctl) begin
            rd_word[MASK_BIT] = mask_q[idx];
            rd_word[PEND_BIT] = pend_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            reg_err <= reg_en & ~(hit_route | hit_ctl);
            if (reg_en && !reg_we) reg_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk #(
    parameter int          N_SRC    = 32,
    parameter int          ADDR_W   = 16,
    parameter int unsigned CTL_BASE = 'h200
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_en,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [63:0]       reg_rdata,
    input logic              reg_err,
    input logic              post_valid,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  pend_q,
    input logic [N_SRC-1:0]  accept
);
    int unsigned a;
    logic        unmapped;

    assign a        = 32'(reg_addr);
    assign unmapped = !(a < N_SRC * 8) &&
                      !(a >= CTL_BASE && a < CTL_BASE + N_SRC * 8);

    p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_en |=> !reg_err);

    p_unmapped_read_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_we && unmapped) |=> (reg_err && reg_rdata == 64'd0));

    p_mapped_ok_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !unmapped) |=> !reg_err);

    p_accept_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (|accept) |=> ((mask_q & pend_q & $past(accept)) == $past(accept)));

    p_accept_posts_r6: assert property (@(posedge clk) disable iff (rst)
        (|accept) |-> ##2 post_valid);

    p_masked_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));
endmodule

bind irq_route_ctrl irq_route_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .CTL_BASE(CTL_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .post_valid (post_valid),
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .accept     (accept)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
    localparam int N   = 32;
    localparam int CTL = 'h200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] dev_irq = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;

    int n_chk  = 0;
    int n_fail = 0;
    int posts  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_route_ctrl u0 (
        .clk(clk), .rst(rst), .dev_irq(dev_irq),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    always @(negedge clk) if (!rst && post_valid) posts++;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] ad, logic [63:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = ad; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] ad, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = ad;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata; e = reg_err;
    endtask

    task automatic rd_chk(string req, logic [15:0] ad, logic [63:0] exp);
        logic [63:0] d; logic e;
        rd(ad, d, e);
        chk(req, d, exp);
    endtask

    // pulse one source; check post timing and content
    task automatic fire(string req, int src, bit exp_post, int cpu, int vec);
        @(negedge clk);
        dev_irq[src] = 1'b1;
        @(negedge clk);
        dev_irq[src] = 1'b0;
        chk({req, " no post yet"}, 64'(post_valid), 64'd0);
        @(negedge clk);
        chk({req, " post valid"}, 64'(post_valid), 64'(exp_post));
        if (exp_post) begin
            chk({req, " post cpu"}, 64'(post_cpu), 64'(cpu));
            chk({req, " post vec"}, 64'(post_vec), 64'(vec));
        end
        @(negedge clk);
        chk({req, " single strobe"}, 64'(post_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 post idle", 64'(post_valid), 64'd0);
        for (int i = 0; i < N; i += 7) begin
            rd_chk("R1 route zero", 16'(i * 8), 64'd0);
            rd_chk("R1 R3 ctl masked", 16'(CTL + i * 8), 64'h4);
        end
    endtask

    task automatic t_route();
        wr(16'(5 * 8), 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R2 fields only", 16'(5 * 8), 64'h1F3F);
        wr(16'(6 * 8 + 3), 64'h0000_0000_0000_0A15);
        rd_chk("R10 low bits ignored", 16'(6 * 8 + 5), 64'h0A15);
        rd_chk("R10 neighbour kept", 16'(5 * 8), 64'h1F3F);
        rd_chk("R12 read data", 16'(CTL + 6 * 8), 64'h4);
    endtask

    task automatic t_masked();
        int p0;
        p0 = posts;
        fire("R5 masked", 5, 1'b0, 0, 0);
        chk("R5 no post", 64'(posts - p0), 64'd0);
        rd_chk("R5 ctl unchanged", 16'(CTL + 5 * 8), 64'h4);
    endtask

    task automatic t_fire_remask();
        int p0;
        wr(16'(CTL + 5 * 8), 64'h0);
        rd_chk("R4 unmask", 16'(CTL + 5 * 8), 64'h0);
        fire("R6 accept", 5, 1'b1, 31, 63);
        rd_chk("R6 R3 masked pending", 16'(CTL + 5 * 8), 64'h5);
        fire("R7 remasked", 5, 1'b0, 0, 0);
        wr(16'(CTL + 5 * 8), 64'h4);
        rd_chk("R4 bit1 zero keeps pend", 16'(CTL + 5 * 8), 64'h5);
        wr(16'(CTL + 5 * 8), 64'h6);
        rd_chk("R4 bit1 clears pend", 16'(CTL + 5 * 8), 64'h4);
        wr(16'(CTL + 5 * 8), 64'h2);
        p0 = posts;
        @(negedge clk);
        dev_irq[5] = 1'b1;
        repeat (6) @(negedge clk);
        dev_irq[5] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 held line posts once", 64'(posts - p0), 64'd1);
        rd_chk("R7 held line ctl", 16'(CTL + 5 * 8), 64'h5);
    endtask

    task automatic t_multi();
        wr(16'(1 * 8), 64'h0101);
        wr(16'(3 * 8), 64'h0303);
        wr(16'(7 * 8), 64'h0707);
        wr(16'(CTL + 1 * 8), 64'h0);
        wr(16'(CTL + 3 * 8), 64'h0);
        wr(16'(CTL + 7 * 8), 64'h0);
        @(negedge clk);
        dev_irq[7] = 1'b1; dev_irq[3] = 1'b1; dev_irq[1] = 1'b1;
        @(negedge clk);
        dev_irq = '0;
        chk("R8 nothing yet", 64'(post_valid), 64'd0);
        for (int k = 0; k < 3; k++) begin
            int s;
            s = (k == 0) ? 1 : (k == 1) ? 3 : 7;
            @(negedge clk);
            chk("R8 valid", 64'(post_valid), 64'd1);
            chk("R8 order cpu", 64'(post_cpu), 64'(s));
            chk("R8 order vec", 64'(post_vec), 64'(s));
        end
        @(negedge clk);
        chk("R8 drained", 64'(post_valid), 64'd0);
    endtask

    task automatic t_unmapped();
        logic [63:0] d; logic e;
        rd(16'h0180, d, e);
        chk("R9 gap reads zero", d, 64'd0);
        chk("R9 gap err", 64'(e), 64'd1);
        @(negedge clk);
        chk("R9 err one cycle", 64'(reg_err), 64'd0);
        rd(16'(CTL + N * 8), d, e);
        chk("R9 past ctl end err", 64'(e), 64'd1);
        wr(16'h0188, 64'h0);
        chk("R9 write err", 64'(reg_err), 64'd1);
        rd_chk("R9 write no effect", 16'(CTL + 6 * 8), 64'h4);
        rd(16'(CTL + 31 * 8), d, e);
        chk("R10 last ctl mapped", 64'(e), 64'd0);
    endtask

    task automatic t_collide();
        int p0;
        wr(16'(9 * 8), 64'h0409);
        wr(16'(CTL + 9 * 8), 64'h0);
        p0 = posts;
        @(negedge clk);
        dev_irq[9] = 1'b1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 16'(CTL + 9 * 8); reg_wdata = 64'h2;
        @(negedge clk);
        dev_irq[9] = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        chk("R11 accepted posts", 64'(post_valid), 64'd1);
        chk("R11 accepted vec", 64'(post_vec), 64'd9);
        rd_chk("R11 accept beats write", 16'(CTL + 9 * 8), 64'h5);
        p0 = posts;
        @(negedge clk);
        dev_irq[10] = 1'b1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 16'(CTL + 10 * 8); reg_wdata = 64'h0;
        @(negedge clk);
        dev_irq[10] = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 masked dropped", 64'(posts - p0), 64'd0);
        rd_chk("R11 write applied", 16'(CTL + 10 * 8), 64'h0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_route();
        t_masked();
        t_fire_remask();
        t_multi();
        t_unmapped();
        t_collide();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end
endmodule